// File: doc/BRIEF.md
# Link Signal Detect Qualifier

This block decides whether a deserialized 8b/10b link carries real Fibre Channel or Gigabit Ethernet traffic. On every character clock it takes one 10-bit received word and a one-bit flag from an analog amplitude comparator. It then gives a registered signal-detect bit. Time is cut into fixed periods of four characters. The verdict formed during one period is driven for the whole of the next period.

A period passes only when every check enabled for it holds on all of its characters. Four checks are combined:
- the amplitude flag stays high;
- the word is never all zeros;
- the word is never all ones;
- a negative-disparity K28.5 comma appears at least once in each long monitoring window.

Two mode inputs remove some of these checks. One selects wrap (rollback or loopback). The other tells the detector to ignore commas.

Top module: `link_sigdet_qual`

## Requirements
- R1: While `rst` is high and after it is released, `sig_det` is 0. The period and window counters restart at release. `sig_det` can first go high at the clock edge that ends the fourth character after release, and only when that first period was clean.
- R2: `sig_det` changes only at the edge that ends a 4-character period. Within the following period it keeps the value decided at that edge.
- R3: When the pattern checks are enabled, receiving `rx_word` = 10'h000 on any character of a period makes `sig_det` 0 for the next period.
- R4: When the pattern checks are enabled, receiving `rx_word` = 10'h3FF on any character of a period makes `sig_det` 0 for the next period.
- R5: If `amp_ok` is 0 on any character of a period, `sig_det` is 0 for the next period. This applies in every mode.
- R6: The comma is the 10-bit pattern 0011111010 with its leftmost bit at `rx_word[0]`, which is `rx_word` = 10'h17C. Windows of WINDOW characters (default 65560) follow one another from reset release. When the comma checks are enabled and a window ends without a comma, only the one period ending with that window is forced low.
- R7: The record of a seen comma is cleared at every window boundary. A comma in one window does not satisfy the next window.
- R8: With `wrap_mode`=0 and `comma_ign`=1, a missing comma has no effect. The zero, ones and amplitude checks stay active.
- R9: With `wrap_mode`=1, the comma, all-zeros and all-ones checks are all off, whatever the value of `comma_ign`. Only the amplitude check remains.
- R10: The mode inputs are sampled while in reset and at each period-ending edge. A change made during a period first applies to the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_word | input | 10 | Received 10-bit character, first bit in bit 0 |
| amp_ok | input | 1 | Amplitude comparator reports adequate swing |
| wrap_mode | input | 1 | Wrap (rollback/loopback) mode select |
| comma_ign | input | 1 | Ignore the comma presence check |
| sig_det | output | 1 | Registered signal-detect verdict |

## Verification
The assertions count their own 4-character phase from reset release. They therefore assume that reset is synchronous and that every clock after release is one character. The bench drives a new word and flag exactly once per clock, on the falling edge, and never holds a character over several edges. The window length must be a multiple of four, so that a window ends on the last character of a period. The bench uses a 16-character window to keep that alignment and a short run time. It changes mode inputs only between characters, so each change falls clearly inside a known period.

// File: rtl/link_sigdet_qual.sv
module link_sigdet_qual #(
  parameter int WORD_W = 10,
  parameter int PERIOD = 4,
  parameter int WINDOW = 65560,
  parameter logic [WORD_W-1:0] COMMA = 10'h17C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              amp_ok,
  input  logic              wrap_mode,
  input  logic              comma_ign,
  output logic              sig_det
);
  localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int WW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [PW-1:0] PER_LAST = PW'(PERIOD - 1);
  localparam logic [WW-1:0] WIN_LAST = WW'(WINDOW - 1);

  logic [PW-1:0] per_cnt;
  logic [WW-1:0] win_cnt;
  logic          fail_q, seen_q, wrap_q, cign_q;

  wire per_end = (per_cnt == PER_LAST);
  wire win_end = (win_cnt == WIN_LAST);
  wire is_k    = (rx_word == COMMA);
  wire pat_en  = !wrap_q;
  wire com_en  = !wrap_q && !cign_q;
  wire bad_pat = pat_en && ((~|rx_word) || (&rx_word));
  wire miss_k  = com_en && win_end && !(seen_q || is_k);
  wire fail_now = !amp_ok || bad_pat || miss_k;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_cnt <= '0;
      win_cnt <= '0;
      fail_q  <= 1'b0;
      seen_q  <= 1'b0;
      sig_det <= 1'b0;
      wrap_q  <= wrap_mode;
      cign_q  <= comma_ign;
    end else begin
      per_cnt <= per_end ? '0 : per_cnt + 1'b1;
      win_cnt <= win_end ? '0 : win_cnt + 1'b1;
      seen_q  <= win_end ? 1'b0 : (seen_q || is_k);
      fail_q  <= per_end ? 1'b0 : (fail_q || fail_now);
      if (per_end) begin
        sig_det <= !(fail_q || fail_now);
        wrap_q  <= wrap_mode;
        cign_q  <= comma_ign;
      end
    end
  end
endmodule

// File: rtl/link_sigdet_qual_chk.sv
module link_sigdet_qual_chk #(
  parameter int WORD_W = 10,
  parameter int PERIOD = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] rx_word,
  input logic              amp_ok,
  input logic              wrap_q,
  input logic              sig_det
);
  localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);
  logic [PW-1:0] ph;
  logic          rst_d;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) ph <= '0;
    else     ph <= (ph == LAST) ? '0 : ph + 1'b1;
  end

  assert_low_after_reset_R1: assert property (@(posedge clk)
    (rst_d === 1'b1) |-> !sig_det);

  assert_hold_in_period_R2: assert property (@(posedge clk) disable iff (rst)
    (ph != LAST) |=> $stable(sig_det));

  assert_zeros_fail_R3: assert property (@(posedge clk) disable iff (rst)
    (ph == LAST && !wrap_q && rx_word == '0) |=> !sig_det);

  assert_ones_fail_R4: assert property (@(posedge clk) disable iff (rst)
    (ph == LAST && !wrap_q && (&rx_word)) |=> !sig_det);

  assert_amp_fail_R5: assert property (@(posedge clk) disable iff (rst)
    (ph == LAST && !amp_ok) |=> !sig_det);
endmodule

bind link_sigdet_qual link_sigdet_qual_chk #(.WORD_W(WORD_W), .PERIOD(PERIOD)) u_chk (
  .clk(clk), .rst(rst), .rx_word(rx_word), .amp_ok(amp_ok),
  .wrap_q(wrap_q), .sig_det(sig_det)
);

// File: tb/link_sigdet_qual_bench.sv
module link_sigdet_qual_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 16;
  localparam logic [9:0] KNEG = 10'h17C;
  localparam logic [9:0] FILL = 10'h155;
  localparam logic [9:0] ZER  = 10'h000;
  localparam logic [9:0] ONE  = 10'h3FF;

  logic clk = 1'b0, rst = 1'b1;
  logic [9:0] rx_word = FILL;
  logic amp_ok = 1'b1, wrap_mode = 1'b0, comma_ign = 1'b0;
  logic sig_det;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_sigdet_qual #(.WINDOW(WIN)) u_link_sigdet_qual (
    .clk(clk), .rst(rst), .rx_word(rx_word), .amp_ok(amp_ok),
    .wrap_mode(wrap_mode), .comma_ign(comma_ign), .sig_det(sig_det)
  );

  task automatic check(input string req, input logic exp);
    total++;
    if (sig_det !== exp) begin
      bad++;
      $display("FAIL %s: sig_det actual=%b expected=%b at %0t", req, sig_det, exp, $time);
    end
  endtask

  task automatic do_reset(input logic w, input logic c);
    @(negedge clk);
    rst = 1'b1; wrap_mode = w; comma_ign = c; rx_word = FILL; amp_ok = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(input logic [9:0] w, input logic a);
    rx_word = w; amp_ok = a;
    @(negedge clk);
  endtask

  // one period: comma at kpos (-1 none), special word sw at spos (-1 none), amp low at apos
  task automatic period(input int kpos, input int spos, input logic [9:0] sw, input int apos);
    for (int i = 0; i < 4; i++) begin
      logic [9:0] w;
      w = FILL;
      if (i == kpos) w = KNEG;
      if (i == spos) w = sw;
      step(w, i != apos);
    end
  endtask

  task automatic t_reset;
    do_reset(1'b0, 1'b0);
    rst = 1'b1;
    check("R1 in reset", 1'b0);
    rst = 1'b0;
    step(KNEG, 1'b1); step(FILL, 1'b1);
    check("R1 not early", 1'b0);
    step(FILL, 1'b1); step(FILL, 1'b1);
    check("R1 first clean period", 1'b1);
    step(FILL, 1'b1); step(ZER, 1'b1);
    check("R2 held mid period", 1'b1);
    step(FILL, 1'b1); step(FILL, 1'b1);
    check("R3 zeros mid period", 1'b0);
  endtask

  task automatic t_zeros;
    do_reset(1'b0, 1'b0);
    period(0, -1, FILL, -1); check("R3 clean", 1'b1);
    period(0, 3, ZER, -1);   check("R3 zeros last char", 1'b0);
    period(1, -1, FILL, -1); check("R3 recover", 1'b1);
  endtask

  task automatic t_ones;
    do_reset(1'b0, 1'b0);
    period(2, -1, FILL, -1); check("R4 clean", 1'b1);
    period(2, 0, ONE, -1);   check("R4 ones first char", 1'b0);
    period(2, -1, FILL, -1); check("R4 recover", 1'b1);
  endtask

  task automatic t_amp;
    do_reset(1'b1, 1'b0);
    period(-1, -1, FILL, -1); check("R5 clean wrap", 1'b1);
    period(-1, -1, FILL, 2);  check("R5 amp low wrap", 1'b0);
    do_reset(1'b0, 1'b1);
    period(-1, -1, FILL, 0);  check("R5 amp low comma-ignore", 1'b0);
    period(-1, -1, FILL, -1); check("R5 recover", 1'b1);
  endtask

  task automatic t_window;
    do_reset(1'b0, 1'b0);
    period(-1, -1, FILL, -1); check("R6 window open p0", 1'b1);
    period(-1, -1, FILL, -1); check("R6 window open p1", 1'b1);
    period(-1, -1, FILL, -1); check("R6 window open p2", 1'b1);
    period(-1, -1, FILL, -1); check("R6 missed comma", 1'b0);
    period(1, -1, FILL, -1);  check("R6 only one period low", 1'b1);
    period(-1, -1, FILL, -1);
    period(-1, -1, FILL, -1);
    period(-1, -1, FILL, -1); check("R6 comma early in window", 1'b1);
  endtask

  task automatic t_restart;
    do_reset(1'b0, 1'b0);
    period(-1, -1, FILL, -1);
    period(-1, -1, FILL, -1);
    period(-1, -1, FILL, -1);
    period(3, -1, FILL, -1);  check("R7 comma on last char", 1'b1);
    period(-1, -1, FILL, -1);
    period(-1, -1, FILL, -1);
    period(-1, -1, FILL, -1);
    period(-1, -1, FILL, -1); check("R7 flag cleared", 1'b0);
  endtask

  task automatic t_cign;
    do_reset(1'b0, 1'b1);
    for (int p = 0; p < 4; p++) period(-1, -1, FILL, -1);
    check("R8 no comma ignored", 1'b1);
    period(-1, 1, ZER, -1); check("R8 zeros still active", 1'b0);
    period(-1, 2, ONE, -1); check("R8 ones still active", 1'b0);
  endtask

  task automatic t_wrap;
    do_reset(1'b1, 1'b0);
    period(-1, 0, ZER, -1); check("R9 zeros ignored", 1'b1);
    period(-1, 3, ONE, -1); check("R9 ones ignored", 1'b1);
    period(-1, -1, FILL, -1);
    period(-1, -1, FILL, -1); check("R9 comma ignored", 1'b1);
    do_reset(1'b1, 1'b1);
    period(-1, 2, ZER, -1);  check("R9 with comma_ign", 1'b1);
  endtask

  task automatic t_mode;
    do_reset(1'b0, 1'b0);
    step(KNEG, 1'b1);
    wrap_mode = 1'b1;
    step(ZER, 1'b1); step(FILL, 1'b1); step(FILL, 1'b1);
    check("R10 wrap not yet active", 1'b0);
    period(-1, 0, ZER, -1); check("R10 wrap active next period", 1'b1);
    do_reset(1'b0, 1'b0);
    period(-1, -1, FILL, -1);
    period(-1, -1, FILL, -1);
    step(FILL, 1'b1);
    comma_ign = 1'b1;
    step(FILL, 1'b1); step(FILL, 1'b1); step(FILL, 1'b1);
    period(-1, -1, FILL, -1); check("R10 comma_ign applied at window end", 1'b1);
    comma_ign = 1'b0;
  endtask

  initial begin
    t_reset();
    t_zeros();
    t_ones();
    t_amp();
    t_window();
    t_restart();
    t_cign();
    t_wrap();
    t_mode();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule